// File: doc/BRIEF.md
# PLL Clock Control Register Block

This block is the software-facing control point for one programmable digital PLL and two auxiliary fixed-rate PLLs inside a clock manager. A simple single-cycle register bus writes four words: a PLL enable word, a rate-select word, a core-source word, and a read-only status word. From the stored fields the block sets the operating mode of the programmable PLL. This includes a forced bypass when the multiplier is too small. It models lock acquisition by counting a divided reference, and it publishes the resulting rate ratio, the lock flags and the core clock source select to the surrounding clock logic.

The digital PLL is controlled by a state machine with five states:
- **EVAL**: entered on reset and on every relevant configuration change; it decides the next state from the stored fields.
- **BYPASS**: forced bypass, low-power bypass or fast-relock bypass.
- **BAD**: illegal mode 0 with a usable multiplier.
- **ACQUIRE**: lock mode, counting internal reference ticks.
- **LOCKED**: lock has been acquired.

Transitions:
- EVAL goes to BYPASS, BAD or ACQUIRE according to the effective mode.
- ACQUIRE goes to LOCKED on the twentieth internal reference tick.
- Any state goes to EVAL when the PLL mode, the multiplier or the divider changes value.

The internal reference ticks once every (divider+1) pulses of `ref_tick`. The analog PLLs and the clock multiplexers themselves sit outside the block.

Top module: `clkpll_ctrl`

## Requirements
- R1: After reset, offset 0x500 reads 0, offset 0x540 reads 0, offset 0x544 reads 2, and status offset 0x520 reads 0x71. Also after reset, `core_src` is 2, `dpll_locked` is 0, `cfg_err` is 0, and the rate outputs are num 1, den 1, doubled num 1.
- R2: A write keeps only the bits under these masks: 0xcf at 0x500, 0x03bfff28 at 0x540, 0x3 at 0x544. Reads return the kept value.
- R3: `aux_locked[0]` is 1 exactly when 0x500 bits [7:6] equal 3, and `aux_locked[1]` exactly when bits [3:2] equal 3. Status bit 9 mirrors `aux_locked[0]` and status bit 8 mirrors `aux_locked[1]`.
- R4: `cfg_err` is 1 in any of these cases:
  - either auxiliary mode is 1 or 2;
  - the PLL mode (0x500 bits [1:0]) is 0 while the multiplier is 2 or more;
  - the core source is 3.
- R5: A multiplier (0x540 bits [21:12]) of 0 or 1 forces bypass whatever the mode. In forced bypass `dpll_locked` never rises and the rate is 1/1.
- R6: With mode 3 and multiplier ≥ 2, `dpll_locked` rises on the edge that samples the 20·(divider+1)-th `ref_tick` pulse counted from ACQUIRE, and not earlier. The divider is 0x540 bits [11:8]. Cycles without `ref_tick` do not count.
- R7: In mode 3 (ACQUIRE or LOCKED), the rate outputs are num = multiplier, den = divider+1 and doubled num = 2·multiplier. In modes 1 and 2, in forced bypass, and in mode 0, all three are 1.
- R8: Status reads 0x70 OR the R3 bits OR a code in bits [1:0]. The code is 3 when the core source is 0, 1 when the PLL is not locked, and 2 when it is locked.
- R9: A write that changes the PLL mode, multiplier or divider clears `dpll_locked` at that edge and restarts the count. The following writes leave lock untouched: rewriting identical values, writes to 0x544, and writes that change only other 0x540 bits.
- R10: `rsv_warn` is 1 for one cycle after a write that sets a reserved bit. The reserved masks are 0xffffff30 at 0x500, 0xfc4000d7 at 0x540, and bits [31:2] at 0x544.
- R11: `core_src` follows 0x544 bits [1:0]: 0 = 32 kHz, 1 = PLL output, 2 = doubled PLL output, 3 = illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and state clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ref_tick | input | 1 | One pulse per reference clock period |
| core_src | output | 2 | Core clock source select |
| aux_locked | output | 2 | Lock flags of the two auxiliary PLLs |
| dpll_locked | output | 1 | Programmable PLL lock flag |
| rate_num | output | 10 | Output rate numerator |
| rate_den | output | 5 | Output rate denominator |
| rate2_num | output | 11 | Doubled output rate numerator |
| cfg_err | output | 1 | Illegal setting present |
| rsv_warn | output | 1 | Reserved bits were written, one-cycle flag |

## Verification
The two auxiliary mode fields are swept over all sixteen combinations. This separates lock (value 3) from illegal (1, 2) and from off (0), and shows which status bit each field lands on. The PLL mode is swept over all four values with a usable multiplier, then over forced bypass, so that the bad, bypass and lock ratios are told apart. Lock delay is measured for dividers 0 to 3, with back-to-back and with gapped reference pulses, so that an off-by-one in either counter or a count of idle cycles shows up. Writes of identical values, of source-only changes and of non-rate bits are contrasted with real rate changes to separate restart from no restart.

// File: rtl/clkpll_pkg.sv
package clkpll_pkg;

    typedef enum logic [2:0] {
        DP_EVAL,
        DP_BYPASS,
        DP_BAD,
        DP_ACQUIRE,
        DP_LOCKED
    } dpll_state_e;

    localparam logic [1:0] MODE_ILLEGAL = 2'd0;
    localparam logic [1:0] MODE_LP_BYP  = 2'd1;
    localparam logic [1:0] MODE_FR_BYP  = 2'd2;
    localparam logic [1:0] MODE_LOCK    = 2'd3;

    localparam logic [1:0] SRC_32K      = 2'd0;
    localparam logic [1:0] SRC_PLL      = 2'd1;
    localparam logic [1:0] SRC_PLL_X2   = 2'd2;
    localparam logic [1:0] SRC_ILLEGAL  = 2'd3;

    localparam logic [1:0] CODE_UNLOCKED = 2'd1;
    localparam logic [1:0] CODE_LOCKED   = 2'd2;
    localparam logic [1:0] CODE_SLOW     = 2'd3;

endpackage

// File: rtl/clkpll_regs.sv
module clkpll_regs #(
    parameter int ADDR_W = 12,
    parameter int MULT_W = 10,
    parameter int DIV_W  = 4,
    parameter logic [ADDR_W-1:0] OFS_EN  = 12'h500,
    parameter logic [ADDR_W-1:0] OFS_SEL = 12'h540,
    parameter logic [ADDR_W-1:0] OFS_SRC = 12'h544
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       en_q,
    output logic [31:0]       sel_q,
    output logic [1:0]        src_q,
    output logic              restart,
    output logic              warn_q
);
    import clkpll_pkg::*;

    localparam int          DIV_LSB  = 8;
    localparam int          MULT_LSB = DIV_LSB + DIV_W;
    localparam int          RATE_MSB = MULT_LSB + MULT_W - 1;
    localparam logic [31:0] EN_KEEP  = 32'h0000_00cf;
    localparam logic [31:0] SEL_KEEP = 32'h03bf_ff28;
    localparam logic [31:0] EN_RSV   = 32'hffff_ff30;
    localparam logic [31:0] SEL_RSV  = 32'hfc40_00d7;
    localparam logic [31:0] SRC_RSV  = 32'hffff_fffc;

    logic        hit_en, hit_sel, hit_src;
    logic [31:0] en_d, sel_d;
    logic [1:0]  src_d;
    logic        warn_d;

    always_comb begin
        hit_en  = wr && (addr == OFS_EN);
        hit_sel = wr && (addr == OFS_SEL);
        hit_src = wr && (addr == OFS_SRC);
        en_d    = hit_en  ? (wdata & EN_KEEP)  : en_q;
        sel_d   = hit_sel ? (wdata & SEL_KEEP) : sel_q;
        src_d   = hit_src ? wdata[1:0] : src_q;
        restart = (en_d[1:0] != en_q[1:0]) ||
                  (sel_d[RATE_MSB:DIV_LSB] != sel_q[RATE_MSB:DIV_LSB]);
        warn_d  = (hit_en  && |(wdata & EN_RSV))  ||
                  (hit_sel && |(wdata & SEL_RSV)) ||
                  (hit_src && |(wdata & SRC_RSV));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            sel_q  <= '0;
            src_q  <= SRC_PLL_X2;
            warn_q <= 1'b0;
        end else begin
            en_q   <= en_d;
            sel_q  <= sel_d;
            src_q  <= src_d;
            warn_q <= warn_d;
        end
    end

endmodule

// File: rtl/clkpll_aux_stat.sv
module clkpll_aux_stat (
    input  logic [1:0] mode,
    output logic       locked,
    output logic       illegal
);
    import clkpll_pkg::*;

    always_comb begin
        locked  = (mode == MODE_LOCK);
        illegal = (mode == MODE_LP_BYP) || (mode == MODE_FR_BYP);
    end

endmodule

// File: rtl/clkpll_dpll_fsm.sv
module clkpll_dpll_fsm #(
    parameter int MULT_W     = 10,
    parameter int DIV_W      = 4,
    parameter int LOCK_TICKS = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     restart,
    input  logic [1:0]               mode,
    input  logic [MULT_W-1:0]        mult,
    input  logic [DIV_W-1:0]         div,
    input  logic                     ref_tick,
    output clkpll_pkg::dpll_state_e  state,
    output logic                     locked,
    output logic                     bad,
    output logic [MULT_W-1:0]        rate_num,
    output logic [DIV_W:0]           rate_den,
    output logic [MULT_W:0]          rate2_num
);
    import clkpll_pkg::*;

    localparam int                CNT_W = $clog2(LOCK_TICKS + 1);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(LOCK_TICKS - 1);

    dpll_state_e      state_d;
    logic [DIV_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fint;
    logic             forced;
    logic             lock_mode;

    assign forced = (mult < MULT_W'(2));
    assign fint   = ref_tick && (pre_q == div);

    // next state
    always_comb begin
        state_d = state;
        if (restart) begin
            state_d = DP_EVAL;
        end else begin
            unique case (state)
                DP_EVAL: begin
                    if (forced || mode == MODE_LP_BYP || mode == MODE_FR_BYP)
                        state_d = DP_BYPASS;
                    else if (mode == MODE_ILLEGAL)
                        state_d = DP_BAD;
                    else
                        state_d = DP_ACQUIRE;
                end
                DP_ACQUIRE: begin
                    if (fint && cnt_q == LAST)
                        state_d = DP_LOCKED;
                end
                DP_BYPASS, DP_BAD, DP_LOCKED: state_d = state;
                default: state_d = DP_EVAL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= DP_EVAL;
        else
            state <= state_d;
    end

    // reference prescaler and lock tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (restart || state != DP_ACQUIRE) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (ref_tick) begin
            if (fint) begin
                pre_q <= '0;
                if (cnt_q != LAST)
                    cnt_q <= cnt_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        lock_mode = (state == DP_ACQUIRE) || (state == DP_LOCKED);
        locked    = (state == DP_LOCKED);
        bad       = (state == DP_BAD);
        if (lock_mode) begin
            rate_num  = mult;
            rate_den  = {1'b0, div} + 1'b1;
            rate2_num = {mult, 1'b0};
        end else begin
            rate_num  = MULT_W'(1);
            rate_den  = (DIV_W+1)'(1);
            rate2_num = (MULT_W+1)'(1);
        end
    end

endmodule

// File: rtl/clkpll_ctrl.sv
module clkpll_ctrl #(
    parameter int ADDR_W     = 12,
    parameter int MULT_W     = 10,
    parameter int DIV_W      = 4,
    parameter int LOCK_TICKS = 20,
    parameter int N_AUX      = 2,
    parameter logic [ADDR_W-1:0] OFS_EN   = 12'h500,
    parameter logic [ADDR_W-1:0] OFS_STAT = 12'h520,
    parameter logic [ADDR_W-1:0] OFS_SEL  = 12'h540,
    parameter logic [ADDR_W-1:0] OFS_SRC  = 12'h544
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ref_tick,
    output logic [1:0]        core_src,
    output logic [N_AUX-1:0]  aux_locked,
    output logic              dpll_locked,
    output logic [MULT_W-1:0] rate_num,
    output logic [DIV_W:0]    rate_den,
    output logic [MULT_W:0]   rate2_num,
    output logic              cfg_err,
    output logic              rsv_warn
);
    import clkpll_pkg::*;

    localparam int DIV_LSB  = 8;
    localparam int MULT_LSB = DIV_LSB + DIV_W;

    logic [31:0]       en_q, sel_q, stat_word;
    logic [1:0]        src_q;
    logic              restart;
    logic              dpll_bad;
    logic [N_AUX-1:0]  aux_bad;
    logic [MULT_W-1:0] mult;
    logic [DIV_W-1:0]  div;
    logic [1:0]        code;
    dpll_state_e       state;

    clkpll_regs #(
        .ADDR_W(ADDR_W), .MULT_W(MULT_W), .DIV_W(DIV_W),
        .OFS_EN(OFS_EN), .OFS_SEL(OFS_SEL), .OFS_SRC(OFS_SRC)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .en_q(en_q), .sel_q(sel_q), .src_q(src_q),
        .restart(restart), .warn_q(rsv_warn)
    );

    // aux PLL k takes its mode from bits [7-4k:6-4k]
    for (genvar k = 0; k < N_AUX; k++) begin : g_aux
        clkpll_aux_stat u_aux (
            .mode   (en_q[7-4*k -: 2]),
            .locked (aux_locked[k]),
            .illegal(aux_bad[k])
        );
    end

    assign mult = sel_q[MULT_LSB +: MULT_W];
    assign div  = sel_q[DIV_LSB  +: DIV_W];

    clkpll_dpll_fsm #(
        .MULT_W(MULT_W), .DIV_W(DIV_W), .LOCK_TICKS(LOCK_TICKS)
    ) u_dpll (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .mode(en_q[1:0]), .mult(mult), .div(div), .ref_tick(ref_tick),
        .state(state), .locked(dpll_locked), .bad(dpll_bad),
        .rate_num(rate_num), .rate_den(rate_den), .rate2_num(rate2_num)
    );

    always_comb begin
        if (src_q == SRC_32K)
            code = CODE_SLOW;
        else if (!dpll_locked)
            code = CODE_UNLOCKED;
        else
            code = CODE_LOCKED;
        stat_word = 32'h0000_0070;
        for (int k = 0; k < N_AUX; k++)
            stat_word[9-k] = aux_locked[k];
        stat_word[1:0] = code;
    end

    always_comb begin
        if (bus_addr == OFS_EN)
            bus_rdata = en_q;
        else if (bus_addr == OFS_SEL)
            bus_rdata = sel_q;
        else if (bus_addr == OFS_SRC)
            bus_rdata = {30'd0, src_q};
        else if (bus_addr == OFS_STAT)
            bus_rdata = stat_word;
        else
            bus_rdata = '0;
    end

    assign core_src = src_q;
    assign cfg_err  = (|aux_bad) || dpll_bad || (src_q == SRC_ILLEGAL);

endmodule

// File: rtl/clkpll_ctrl_chk.sv
module clkpll_ctrl_chk #(
    parameter int MULT_W = 10,
    parameter int DIV_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic                    restart,
    input logic                    dpll_locked,
    input logic                    rsv_warn,
    input logic [1:0]              aux_locked,
    input logic [31:0]             stat_word,
    input logic [MULT_W-1:0]       mult,
    input logic [DIV_W-1:0]        div,
    input logic [MULT_W-1:0]       rate_num,
    input logic [DIV_W:0]          rate_den,
    input logic [MULT_W:0]         rate2_num,
    input clkpll_pkg::dpll_state_e state
);
    import clkpll_pkg::*;

    a_r9_restart_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !dpll_locked);

    a_r5_forced_bypass_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (mult < MULT_W'(2)) |-> !dpll_locked);

    a_r6_lock_from_acquire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dpll_locked) |-> ($past(state) == DP_ACQUIRE));

    a_r7_locked_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        dpll_locked |-> (rate_num == mult && rate_den == ({1'b0, div} + 1'b1)
                         && rate2_num == {mult, 1'b0}));

    a_r3_status_aux_bits: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[9:8] == {aux_locked[0], aux_locked[1]});

    a_r10_warn_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_warn |-> $past(bus_wr));

endmodule

bind clkpll_ctrl clkpll_ctrl_chk #(.MULT_W(MULT_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .restart(restart),
    .dpll_locked(dpll_locked), .rsv_warn(rsv_warn),
    .aux_locked(aux_locked[1:0]), .stat_word(stat_word),
    .mult(mult), .div(div), .rate_num(rate_num), .rate_den(rate_den),
    .rate2_num(rate2_num), .state(state)
);

// File: tb/clkpll_ctrl_tb.sv
module clkpll_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_tick = 1'b0;
    logic [1:0]  core_src;
    logic [1:0]  aux_locked;
    logic        dpll_locked;
    logic [9:0]  rate_num;
    logic [4:0]  rate_den;
    logic [10:0] rate2_num;
    logic        cfg_err;
    logic        rsv_warn;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    clkpll_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_tick(ref_tick),
        .core_src(core_src), .aux_locked(aux_locked), .dpll_locked(dpll_locked),
        .rate_num(rate_num), .rate_den(rate_den), .rate2_num(rate2_num),
        .cfg_err(cfg_err), .rsv_warn(rsv_warn)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ref_tick = 1'b1;
            @(posedge clk);
            @(negedge clk);
            ref_tick = 1'b0;
        end
    endtask

    task automatic rates(input string tag, input int num, input int den);
        chk({tag, " num"}, 32'(rate_num), 32'(num));
        chk({tag, " den"}, 32'(rate_den), 32'(den));
        chk({tag, " dbl"}, 32'(rate2_num), (num == 1 && den == 1) ? 32'd1 : 32'(2*num));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(3);

        // R1 reset state
        rd("R1 en", 12'h500, 32'h0);
        rd("R1 sel", 12'h540, 32'h0);
        rd("R1 src", 12'h544, 32'h2);
        rd("R1 status", 12'h520, 32'h71);
        chk("R1 core_src", 32'(core_src), 32'd2);
        chk("R1 locked", 32'(dpll_locked), 32'd0);
        chk("R1 cfg_err", 32'(cfg_err), 32'd0);
        rates("R1 rate", 1, 1);

        // R2 masks, R10 warn pulse, R5 forced bypass with mode 3
        wr(12'h500, 32'hffff_ffff);
        chk("R10 warn en", 32'(rsv_warn), 32'd1);
        idle(1);
        chk("R10 warn clears", 32'(rsv_warn), 32'd0);
        rd("R2 en mask", 12'h500, 32'hcf);
        chk("R3 both aux", 32'(aux_locked), 32'd3);
        ticks(60);
        chk("R5 forced mult0 no lock", 32'(dpll_locked), 32'd0);
        rates("R5 forced rate", 1, 1);
        chk("R4 forced no err", 32'(cfg_err), 32'd0);
        wr(12'h540, 32'hffff_ffff);
        chk("R10 warn sel", 32'(rsv_warn), 32'd1);
        rd("R2 sel mask", 12'h540, 32'h03bf_ff28);
        wr(12'h544, 32'hffff_ffff);
        rd("R2 src mask", 12'h544, 32'h3);
        chk("R11 core_src 3", 32'(core_src), 32'd3);
        chk("R4 src illegal", 32'(cfg_err), 32'd1);
        wr(12'h544, 32'h2);
        chk("R10 clean write no warn", 32'(rsv_warn), 32'd0);
        wr(12'h540, 32'h0);

        // R3/R4 aux sweep
        for (int m0 = 0; m0 < 4; m0++) begin
            for (int m1 = 0; m1 < 4; m1++) begin
                logic [31:0] st;
                bit e;
                wr(12'h500, 32'((m0 << 6) | (m1 << 2) | 1));
                idle(1);
                st = 32'h71 | ((m0 == 3) ? 32'h200 : 0) | ((m1 == 3) ? 32'h100 : 0);
                e = (m0 == 1 || m0 == 2 || m1 == 1 || m1 == 2);
                chk("R3 aux_locked", 32'(aux_locked), 32'({m1 == 3, m0 == 3}));
                rd("R3 R8 status", 12'h520, st);
                chk("R4 aux err", 32'(cfg_err), 32'(e));
            end
        end

        // R7/R4 mode sweep with mult 5, div 0
        wr(12'h500, 32'h1);
        wr(12'h540, 32'h5000);
        for (int m = 0; m < 4; m++) begin
            wr(12'h500, 32'(m));
            idle(1);
            chk("R4 mode err", 32'(cfg_err), 32'(m == 0));
            if (m == 3) rates("R7 lock ratio", 5, 1);
            else        rates("R7 bypass ratio", 1, 1);
        end
        // R5 mult 1 forces bypass even in mode 0 and 3
        wr(12'h540, 32'h1000);
        idle(1);
        ticks(40);
        chk("R5 mult1 no lock", 32'(dpll_locked), 32'd0);
        rates("R5 mult1 rate", 1, 1);
        wr(12'h500, 32'h0);
        idle(1);
        chk("R5 mode0 forced no err", 32'(cfg_err), 32'd0);

        // R6 lock delay sweep
        for (int d = 0; d < 4; d++) begin
            for (int gap = 0; gap < 2; gap++) begin
                int n;
                wr(12'h500, 32'h1);
                wr(12'h540, 32'((6 << 12) | (d << 8)));
                wr(12'h500, 32'h3);
                idle(1);
                n = 20 * (d + 1);
                for (int k = 1; k <= n; k++) begin
                    ticks(1);
                    if (k == n - 1) chk("R6 not yet locked", 32'(dpll_locked), 32'd0);
                    if (k == n)     chk("R6 locked at count", 32'(dpll_locked), 32'd1);
                    if (gap == 1) idle(2);
                end
                rates("R7 locked ratio", 6, d + 1);
                rd("R8 locked code", 12'h520, 32'h72);
            end
        end

        // R9 restart rules
        wr(12'h540, 32'h6000);
        idle(1);
        ticks(20);
        chk("R9 relock div0", 32'(dpll_locked), 32'd1);
        wr(12'h540, 32'h6000);
        idle(1);
        chk("R9 same value keeps lock", 32'(dpll_locked), 32'd1);
        wr(12'h544, 32'h0);
        chk("R9 src write keeps lock", 32'(dpll_locked), 32'd1);
        rd("R8 slow code", 12'h520, 32'h73);
        chk("R11 core_src 0", 32'(core_src), 32'd0);
        wr(12'h544, 32'h1);
        rd("R8 pll code", 12'h520, 32'h72);
        chk("R11 core_src 1", 32'(core_src), 32'd1);
        wr(12'h540, 32'h6020);
        chk("R9 other bits keep lock", 32'(dpll_locked), 32'd1);
        rd("R2 other bit stored", 12'h540, 32'h6020);
        wr(12'h540, 32'h7020);
        chk("R9 mult change drops lock", 32'(dpll_locked), 32'd0);
        rd("R8 unlocked code", 12'h520, 32'h71);
        idle(1);
        rates("R7 new ratio", 7, 1);
        ticks(20);
        chk("R9 relock after change", 32'(dpll_locked), 32'd1);
        wr(12'h500, 32'h2);
        chk("R9 mode change drops lock", 32'(dpll_locked), 32'd0);
        idle(1);
        rates("R7 fast relock bypass", 1, 1);
        wr(12'h544, 32'h0);
        rd("R8 slow code unlocked", 12'h520, 32'h73);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule